// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges every reset source of a small 8-bit microcontroller into one active-low system reset. It runs on the oscillator clock. The sources are power-up, an external reset pin, a watchdog time-out and an illegal instruction-fetch address. On power-up the reset is held for a fixed oscillator stabilization delay. After that delay it stays asserted until every other source has gone away. Losing power asserts the reset at once, without waiting for a clock edge. Every other release is synchronous to the oscillator clock.

The CPU reports each opcode fetch with a strobe and its address. A fetch into the I/O register window, or into an address that belongs to none of the parameterized RAM, ROM and vector windows, triggers an internal reset. That reset, and the one from a watchdog time-out, is stretched to a fixed minimum length, so a one-cycle request still resets all logic. A cause register records which sources started or joined the last reset. A one-cycle mode-latch enable lets the mode inputs be re-sampled, but only when the reset came from power-up or the external pin.

Top module: `rstc_ctrl`

## Requirements
- R1: `pwr_good` low forces `sys_rst_n` low and `rst_cause` to 4'b0001 at once, with no clock edge needed. After `pwr_good` rises, `sys_rst_n` stays low for exactly `POR_CYCLES` clock cycles and rises on the next edge after that, provided no other source is active.
- R2: If another source is still active when the power-up delay ends, `sys_rst_n` stays low until that source has cleared.
- R3: A fetch (`fetch_vld` high) is illegal when its address lies inside [IO_LO, IO_HI], or outside all three of [RAM_LO, RAM_HI], [ROM_LO, ROM_HI] and [VEC_LO, VEC_HI]. An illegal fetch triggers a reset. A legal fetch leaves `sys_rst_n` high.
- R4: A single-cycle illegal-fetch or watchdog request sampled on edge k drives `sys_rst_n` low from edge k+1, for exactly `STRETCH_CYCLES` cycles.
- R5: `wdt_expire` triggers a reset only while `wdt_en` is high. With `wdt_en` low it has no effect.
- R6: `ext_rst_pin_n` passes through two synchronizer flops. A low pin drives `sys_rst_n` low after the third clock edge. A released pin lets `sys_rst_n` rise after the third clock edge, provided no other source is active.
- R7: The bits of `rst_cause` are: bit0 power-up, bit1 external pin, bit2 watchdog, bit3 illegal fetch. While the block is out of reset, a new trigger replaces the register with the triggering sources. While the block is in reset, further active sources are OR-ed in.
- R8: `mode_latch_en` pulses high for exactly the first cycle after `sys_rst_n` rises, and only if the cause has the power-up or external-pin bit set. It never pulses after a reset caused only by the watchdog or an illegal fetch.
- R9: Fetch and watchdog requests are ignored while `sys_rst_n` is low. They neither lengthen the reset nor change `rst_cause`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| pwr_good | input | 1 | High while supply and oscillator are up; low acts as asynchronous power-on reset |
| ext_rst_pin_n | input | 1 | External reset pin level, active low, asynchronous |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_expire | input | 1 | Watchdog time-out pulse |
| fetch_vld | input | 1 | Opcode fetch strobe |
| fetch_addr | input | ADDR_W | Opcode fetch address |
| sys_rst_n | output | 1 | System reset, active low |
| rst_cause | output | 4 | Sources of the last reset |
| mode_latch_en | output | 1 | One-cycle enable to re-sample the operating-mode inputs |

## Verification
The bench sweeps every fetch address of a small 8-bit configuration and computes legality from its own copy of the window limits. A decoder with an off-by-one window edge would reset on a legal boundary address or miss an illegal one. Stretch length and latency are measured for each illegal fetch, which exposes a stretcher that runs one cycle short or long. Holding the pin low across the end of the power-up delay, and fetching an illegal address during that hold, catches a controller that releases as soon as its own counter expires or that lets gated requests extend the reset. The mode-latch pulse is checked after each kind of reset, so a design that re-latches the mode after a watchdog or illegal-fetch reset is reported.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int CZ_POR = 0;
  localparam int CZ_EXT = 1;
  localparam int CZ_WDT = 2;
  localparam int CZ_ILA = 3;
  localparam int CZ_W   = 4;

  typedef logic [CZ_W-1:0] cause_t;

  // Out of reset, a new trigger replaces the record; in reset, sources accumulate.
  function automatic cause_t cause_next(logic released, cause_t cur, cause_t ev);
    if (released) return (|ev) ? ev : cur;
    return cur | ev;
  endfunction
endpackage

// File: rtl/rstc_sync2.sv
module rstc_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rstc_fetch_chk.sv
module rstc_fetch_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] IO_LO  = 'h0000,
  parameter logic [ADDR_W-1:0] IO_HI  = 'h003F,
  parameter logic [ADDR_W-1:0] RAM_LO = 'h0040,
  parameter logic [ADDR_W-1:0] RAM_HI = 'h023F,
  parameter logic [ADDR_W-1:0] ROM_LO = 'h8000,
  parameter logic [ADDR_W-1:0] ROM_HI = 'hBFFF,
  parameter logic [ADDR_W-1:0] VEC_LO = 'hFFF0,
  parameter logic [ADDR_W-1:0] VEC_HI = 'hFFFF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              illegal
);
  function automatic logic in_win(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] lo,
                                  logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  logic in_io, in_mapped;

  always_comb begin
    in_io     = in_win(addr, IO_LO, IO_HI);
    in_mapped = in_win(addr, RAM_LO, RAM_HI) | in_win(addr, ROM_LO, ROM_HI)
              | in_win(addr, VEC_LO, VEC_HI);
    illegal   = in_io | ~in_mapped;
  end
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (trig)         cnt <= CW'(CYCLES);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

  // R4: a running stretch counts down by one per cycle
  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !trig) |=> (cnt == $past(cnt) - 1'b1));

  // R4: a request always starts a stretch
  a_r4_trig_starts: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> active);
endmodule

// File: rtl/rstc_por_timer.sv
module rstc_por_timer #(
  parameter int CYCLES = 8192
) (
  input  logic clk,
  input  logic rst_n,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  assign busy = (cnt != CW'(CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (busy)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rstc_ctrl.sv
module rstc_ctrl
  import rstc_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int POR_CYCLES     = 8192,
  parameter int STRETCH_CYCLES = 4,
  parameter logic [ADDR_W-1:0] IO_LO  = 'h0000,
  parameter logic [ADDR_W-1:0] IO_HI  = 'h003F,
  parameter logic [ADDR_W-1:0] RAM_LO = 'h0040,
  parameter logic [ADDR_W-1:0] RAM_HI = 'h023F,
  parameter logic [ADDR_W-1:0] ROM_LO = 'h8000,
  parameter logic [ADDR_W-1:0] ROM_HI = 'hBFFF,
  parameter logic [ADDR_W-1:0] VEC_LO = 'hFFF0,
  parameter logic [ADDR_W-1:0] VEC_HI = 'hFFFF
) (
  input  logic              clk_osc,
  input  logic              pwr_good,
  input  logic              ext_rst_pin_n,
  input  logic              wdt_en,
  input  logic              wdt_expire,
  input  logic              fetch_vld,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              sys_rst_n,
  output logic [CZ_W-1:0]   rst_cause,
  output logic              mode_latch_en
);
  logic   ext_sync, ext_act, por_busy, addr_bad;
  logic   ila_trig, wdt_trig, ila_act, wdt_act;
  logic   req_any, rel_now;
  cause_t ev, cause_q;

  rstc_sync2 #(.RST_VAL(1'b1)) u_sync (
    .clk(clk_osc), .rst_n(pwr_good), .d(ext_rst_pin_n), .q(ext_sync));

  rstc_por_timer #(.CYCLES(POR_CYCLES)) u_por (
    .clk(clk_osc), .rst_n(pwr_good), .busy(por_busy));

  rstc_fetch_chk #(
    .ADDR_W(ADDR_W), .IO_LO(IO_LO), .IO_HI(IO_HI), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI),
    .ROM_LO(ROM_LO), .ROM_HI(ROM_HI), .VEC_LO(VEC_LO), .VEC_HI(VEC_HI)
  ) u_chk (
    .addr(fetch_addr), .illegal(addr_bad));

  // Requests are only honoured while the system is running (R9)
  assign ext_act  = ~ext_sync;
  assign ila_trig = fetch_vld & addr_bad & sys_rst_n;
  assign wdt_trig = wdt_en & wdt_expire & sys_rst_n;

  rstc_stretch #(.CYCLES(STRETCH_CYCLES)) u_ila (
    .clk(clk_osc), .rst_n(pwr_good), .trig(ila_trig), .active(ila_act));

  rstc_stretch #(.CYCLES(STRETCH_CYCLES)) u_wdt (
    .clk(clk_osc), .rst_n(pwr_good), .trig(wdt_trig), .active(wdt_act));

  assign req_any = por_busy | ext_act | ila_act | wdt_act;
  assign rel_now = ~sys_rst_n & ~req_any;

  always_comb begin
    ev         = '0;
    ev[CZ_POR] = por_busy;
    ev[CZ_EXT] = ext_act;
    ev[CZ_WDT] = wdt_trig;
    ev[CZ_ILA] = ila_trig;
  end

  always_ff @(posedge clk_osc or negedge pwr_good) begin
    if (!pwr_good) begin
      sys_rst_n     <= 1'b0;
      cause_q       <= cause_t'(1) << CZ_POR;
      mode_latch_en <= 1'b0;
    end else begin
      sys_rst_n     <= ~req_any;
      cause_q       <= cause_next(sys_rst_n, cause_q, ev);
      mode_latch_en <= rel_now & (cause_q[CZ_POR] | cause_q[CZ_EXT]);
    end
  end

  assign rst_cause = cause_q;

  // R1: the power-up delay keeps the system in reset
  a_r1_por_holds: assert property (@(posedge clk_osc) disable iff (!pwr_good)
    por_busy |=> !sys_rst_n);

  // R2: release only after every source had cleared
  a_r2_release_all_clear: assert property (@(posedge clk_osc) disable iff (!pwr_good)
    $rose(sys_rst_n) |-> !$past(req_any));

  // R3: an illegal fetch reaches the output two edges later
  a_r3_bad_fetch_resets: assert property (@(posedge clk_osc) disable iff (!pwr_good)
    ila_trig |-> ##2 !sys_rst_n);

  // R8: the mode-latch enable appears only in the release cycle
  a_r8_latch_on_release: assert property (@(posedge clk_osc) disable iff (!pwr_good)
    mode_latch_en |-> $rose(sys_rst_n));

  // R7: a trigger while running records exactly the triggering source
  a_r7_cause_replaced: assert property (@(posedge clk_osc) disable iff (!pwr_good)
    (sys_rst_n && wdt_trig && !ila_trig && !ext_act) |=> (rst_cause == (cause_t'(1) << CZ_WDT)));
endmodule

// File: tb/sim_rstc_ctrl.sv
module sim_rstc_ctrl;
  localparam int AW = 8;
  localparam int P  = 20;
  localparam int S  = 4;

  logic clk = 1'b0;
  logic pwr_good = 1'b0, pin_n = 1'b1, wen = 1'b0, wexp = 1'b0, fv = 1'b0;
  logic [AW-1:0] fa = '0;
  logic sys_n, ml;
  logic [3:0] cause;

  int checks = 0;
  int errs   = 0;

  always #5 clk = ~clk;

  rstc_ctrl #(
    .ADDR_W(AW), .POR_CYCLES(P), .STRETCH_CYCLES(S),
    .IO_LO(8'h00), .IO_HI(8'h07), .RAM_LO(8'h10), .RAM_HI(8'h2F),
    .ROM_LO(8'h80), .ROM_HI(8'hDF), .VEC_LO(8'hF8), .VEC_HI(8'hFF)
  ) u0 (
    .clk_osc(clk), .pwr_good(pwr_good), .ext_rst_pin_n(pin_n), .wdt_en(wen),
    .wdt_expire(wexp), .fetch_vld(fv), .fetch_addr(fa), .sys_rst_n(sys_n),
    .rst_cause(cause), .mode_latch_en(ml));

  function automatic bit legal(int a);
    if (a < 8) return 1'b0;
    return (a >= 16 && a <= 47) || (a >= 128 && a <= 223) || (a >= 248);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // From a sample where sys_n is high: negedges until low, then low length, any mode pulse
  task automatic measure(output int tl, output int ll, output bit ml_any);
    ml_any = ml;
    tl = 0;
    while (sys_n && tl < 10) begin @(negedge clk); tl++; ml_any |= ml; end
    ll = 0;
    while (!sys_n && ll < 60) begin ll++; @(negedge clk); ml_any |= ml; end
  endtask

  // From a low reset: negedges until high; ml sampled at the first high sample
  task automatic wait_high(output int n, output bit mlh);
    n = 0;
    while (!sys_n && n < 200) begin @(negedge clk); n++; end
    mlh = ml;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int n, tl, ll;
    bit mf;
    repeat (3) @(negedge clk);
    chk("R1 reset sys", sys_n, 0);
    chk("R1 reset cause", cause, 1);
    chk("R8 reset latch", ml, 0);

    // R1 power-up delay
    pwr_good = 1'b1;
    wait_high(n, mf);
    chk("R1 por length", n, P + 1);
    chk("R8 latch after por", mf, 1);
    chk("R7 cause por", cause, 1);
    @(negedge clk);
    chk("R8 latch one cycle", ml, 0);

    // R1 asynchronous assertion on power loss
    pwr_good = 1'b0;
    #1;
    chk("R1 async assert", sys_n, 0);
    chk("R1 cause cleared", cause, 1);

    // R2 pin held past the delay, R9 illegal fetch during it
    pin_n = 1'b0;
    @(negedge clk);
    pwr_good = 1'b1;
    repeat (P + 8) @(negedge clk);
    chk("R2 held past delay", sys_n, 0);
    fa = 8'h03; fv = 1'b1;
    @(negedge clk);
    fv = 1'b0;
    wen = 1'b1; wexp = 1'b1;
    @(negedge clk);
    wexp = 1'b0; wen = 1'b0;
    pin_n = 1'b1;
    wait_high(n, mf);
    chk("R2 R6 release latency", n, 3);
    chk("R9 cause unchanged", cause, 3);
    chk("R8 latch after ext", mf, 1);
    repeat (2) @(negedge clk);

    // R6 runtime pin reset
    pin_n = 1'b0;
    measure(tl, ll, mf);
    chk("R6 assert latency", tl, 3);
    repeat (4) @(negedge clk);
    pin_n = 1'b1;
    wait_high(n, mf);
    chk("R6 release latency", n, 3);
    chk("R7 cause ext", cause, 2);
    chk("R8 latch ext", mf, 1);
    repeat (2) @(negedge clk);

    // R5 disabled watchdog
    wen = 1'b0; wexp = 1'b1;
    @(negedge clk);
    wexp = 1'b0;
    measure(tl, ll, mf);
    chk("R5 disabled no reset", ll, 0);
    chk("R5 cause kept", cause, 2);

    // R5 R4 enabled watchdog
    wen = 1'b1; wexp = 1'b1;
    @(negedge clk);
    wexp = 1'b0; wen = 1'b0;
    measure(tl, ll, mf);
    chk("R4 wdt latency", tl, 1);
    chk("R4 wdt length", ll, S);
    chk("R7 cause wdt", cause, 4);
    chk("R8 no latch wdt", mf, 0);

    // R3 R4 sweep of every address
    for (int a = 0; a < 256; a++) begin
      fa = a[7:0]; fv = 1'b1;
      @(negedge clk);
      fv = 1'b0;
      measure(tl, ll, mf);
      if (legal(a)) begin
        chk($sformatf("R3 legal addr %0d", a), tl * 100 + ll, 1000);
      end else begin
        chk($sformatf("R3 R4 illegal addr %0d", a), tl * 100 + ll, 100 + S);
        chk($sformatf("R7 cause ila %0d", a), cause, 8);
        chk($sformatf("R8 no latch ila %0d", a), mf, 0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule